// File: doc/BRIEF.md
# Configuration Memory Controller with Security Lock

This block owns the configuration bits of a programmable logic device: the array connection cells and macrocell selects that the rest of the device reads continuously through a flat `cfgBits` bus. A host issues single-cycle commands with an opcode, a word address, a data byte and a 24-bit signature value. The commands are erase-all, program, verify-read, lock, signature write and signature read. Programming only sets bits: a program command ORs its data into the addressed word. Only erase-all returns bits to zero, which opens every connection.

A security lock guards the stored pattern. Once it is set, verify-reads and every kind of programming are refused, and the only way out is a full erase-all. Erase-all wipes the array, the signature and the lock. The signature register stays readable while the device is locked, so a locked part can still report which pattern or revision it holds. Erase-all walks the memory one word per cycle behind a `busy` flag. Every other command finishes in one cycle. Each accepted command ends with a one-cycle `done` pulse, and a refused command also raises `cmdErr`.

Top module: `cfg_store`

## Requirements
- R1: After reset, `busy`, `done`, `cmdErr`, `locked`, `rdData`, `sigOut` and every bit of `cfgBits` are 0.
- R2: Program (opcode 1) on an unlocked device ORs `cmdData` into the word at `cmdAddr`. Word a occupies `cfgBits[a*DATA_W +: DATA_W]`. The change is visible, and `done` is 1, in the cycle after the accepting edge.
- R3: Verify (opcode 2) on an unlocked device loads the addressed word into `rdData`, with `done` high, one cycle after acceptance.
- R4: Erase-all (opcode 0) raises `busy` for exactly 2**ADDR_W cycles. Afterwards every configuration word, the signature and the lock are 0, and `done` pulses in the first cycle with `busy` low.
- R5: While `busy` is high, the block ignores `cmdValid` entirely: it changes no memory and produces no `done` for that command.
- R6: Lock (opcode 3) sets `locked` one cycle after acceptance and pulses `done` without `cmdErr`.
- R7: While locked, program, verify and signature write (opcode 4) are refused. `cmdErr` and `done` pulse together, memory and signature stay unchanged, and a refused verify returns `rdData` = 0.
- R8: Signature write stores `cmdSig` when unlocked. Signature read (opcode 5) copies the stored signature to `sigOut`, and it succeeds while locked.
- R9: Opcodes 6 and 7 are refused with `cmdErr` and change no stored state.
- R10: `done` and `cmdErr` are one-cycle pulses per accepted command, and `cmdErr` never appears without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 3 | Opcode (0 erase, 1 program, 2 verify, 3 lock, 4 sig write, 5 sig read) |
| cmdAddr | input | ADDR_W | Word address |
| cmdData | input | DATA_W | Program data |
| cmdSig | input | SIG_W | Signature value for signature write |
| busy | output | 1 | Erase-all in progress |
| done | output | 1 | Command completion pulse |
| cmdErr | output | 1 | Command refused pulse |
| locked | output | 1 | Security lock state |
| rdData | output | DATA_W | Verify result |
| sigOut | output | SIG_W | Signature read result |
| cfgBits | output | 2**ADDR_W*DATA_W | All configuration words, flat |

## Verification
A corrupted word shows on `cfgBits` in the cycle after the program or erase step that caused it, because the bus is continuous. The full sweep compares every word after each pass. A lock flag held in the wrong state shows one cycle later as a missing or spurious `cmdErr`, or as nonzero `rdData` on a locked verify. An erase walker that is off by one shows as a wrong `busy` length, or as a residual word once `busy` falls. A command that is wrongly accepted during erase shows as a set bit after the wipe has completed.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    OP_ERASE  = 3'd0,
    OP_PROG   = 3'd1,
    OP_VERIFY = 3'd2,
    OP_LOCK   = 3'd3,
    OP_SIGWR  = 3'd4,
    OP_SIGRD  = 3'd5
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic prog;
    logic rdWord;
    logic rdZero;
    logic wipe;
    logic wipeLast;
    logic setLock;
    logic sigWr;
    logic sigRd;
  } dpCtl_t;
endpackage

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic              locked,
  output dpCtl_t            ctl,
  output logic [ADDR_W-1:0] wipeAddr,
  output logic              busy,
  output logic              done,
  output logic              cmdErr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic              erasing;
  logic [ADDR_W-1:0] wipeCnt;
  logic              accept;
  logic              refuse;
  logic              wipeEnd;

  assign accept   = cmdValid && !erasing;
  assign wipeEnd  = erasing && (wipeCnt == LAST_ADDR);
  assign wipeAddr = wipeCnt;
  assign busy     = erasing;

  always_comb begin
    ctl    = '0;
    refuse = 1'b0;
    if (accept) begin
      case (cmdOp)
        OP_ERASE:  ;
        OP_PROG:   if (locked) refuse = 1'b1; else ctl.prog = 1'b1;
        OP_VERIFY: begin
          if (locked) begin
            refuse     = 1'b1;
            ctl.rdZero = 1'b1;
          end else begin
            ctl.rdWord = 1'b1;
          end
        end
        OP_LOCK:   ctl.setLock = 1'b1;
        OP_SIGWR:  if (locked) refuse = 1'b1; else ctl.sigWr = 1'b1;
        OP_SIGRD:  ctl.sigRd = 1'b1;
        default:   refuse = 1'b1;
      endcase
    end
    ctl.wipe     = erasing;
    ctl.wipeLast = wipeEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      erasing <= 1'b0;
      wipeCnt <= '0;
      done    <= 1'b0;
      cmdErr  <= 1'b0;
    end else begin
      done   <= (accept && (cmdOp != OP_ERASE)) || wipeEnd;
      cmdErr <= refuse;
      if (accept && (cmdOp == OP_ERASE)) begin
        erasing <= 1'b1;
        wipeCnt <= '0;
      end else if (erasing) begin
        wipeCnt <= wipeCnt + 1'b1;
        if (wipeEnd) erasing <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_store_dp.sv
module cfg_store_dp
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 24
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpCtl_t                          ctl,
  input  logic [ADDR_W-1:0]               cmdAddr,
  input  logic [DATA_W-1:0]               cmdData,
  input  logic [SIG_W-1:0]                cmdSig,
  input  logic [ADDR_W-1:0]               wipeAddr,
  output logic                            locked,
  output logic [DATA_W-1:0]               rdData,
  output logic [SIG_W-1:0]                sigOut,
  output logic [(2**ADDR_W)*DATA_W-1:0]   cfgBits
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic [SIG_W-1:0]  sigReg;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        words[i] <= '0;
      end else if (ctl.wipe && (wipeAddr == ADDR_W'(i))) begin
        words[i] <= '0;
      end else if (ctl.prog && (cmdAddr == ADDR_W'(i))) begin
        words[i] <= words[i] | cmdData;
      end
    end
    assign cfgBits[i*DATA_W +: DATA_W] = words[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigReg <= '0;
      locked <= 1'b0;
      rdData <= '0;
      sigOut <= '0;
    end else begin
      if (ctl.wipeLast)   sigReg <= '0;
      else if (ctl.sigWr) sigReg <= cmdSig;
      if (ctl.wipeLast)     locked <= 1'b0;
      else if (ctl.setLock) locked <= 1'b1;
      if (ctl.rdWord)      rdData <= words[cmdAddr];
      else if (ctl.rdZero) rdData <= '0;
      if (ctl.sigRd) sigOut <= sigReg;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  input  logic [2:0]                    cmdOp,
  input  logic [ADDR_W-1:0]             cmdAddr,
  input  logic [DATA_W-1:0]             cmdData,
  input  logic [SIG_W-1:0]              cmdSig,
  output logic                          busy,
  output logic                          done,
  output logic                          cmdErr,
  output logic                          locked,
  output logic [DATA_W-1:0]             rdData,
  output logic [SIG_W-1:0]              sigOut,
  output logic [(2**ADDR_W)*DATA_W-1:0] cfgBits
);
  dpCtl_t            ctl;
  logic [ADDR_W-1:0] wipeAddr;

  cfg_store_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .locked(locked), .ctl(ctl), .wipeAddr(wipeAddr),
    .busy(busy), .done(done), .cmdErr(cmdErr)
  );

  cfg_store_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdSig(cmdSig), .wipeAddr(wipeAddr),
    .locked(locked), .rdData(rdData), .sigOut(sigOut), .cfgBits(cfgBits)
  );
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cmdValid,
  input logic [2:0]                    cmdOp,
  input logic                          busy,
  input logic                          done,
  input logic                          cmdErr,
  input logic                          locked,
  input logic [(2**ADDR_W)*DATA_W-1:0] cfgBits
);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> done);

  // R4
  erase_end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && !locked));

  // R5
  erase_only_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ((cfgBits & ~$past(cfgBits)) == '0));

  // R7
  locked_prog_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && locked && cmdOp == OP_PROG) |=> ($stable(cfgBits) && cmdErr));

  // R6
  lock_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp == OP_LOCK) |=> (locked && done && !cmdErr));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp[2:1] == 2'b11) |=> (cmdErr && $stable(cfgBits)));
endmodule

bind cfg_store cfg_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
  .done(done), .cmdErr(cmdErr), .locked(locked), .cfgBits(cfgBits)
);

// File: tb/cfg_store_test.sv
`timescale 1ns/1ps
module cfg_store_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SW = 24;
  localparam int DEPTH = 2 ** AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic [SW-1:0] cmdSig = '0;
  logic busy, done, cmdErr, locked;
  logic [DW-1:0] rdData;
  logic [SW-1:0] sigOut;
  logic [DEPTH*DW-1:0] cfgBits;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  cfg_store #(.ADDR_W(AW), .DATA_W(DW), .SIG_W(SW)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdSig(cmdSig),
    .busy(busy), .done(done), .cmdErr(cmdErr), .locked(locked),
    .rdData(rdData), .sigOut(sigOut), .cfgBits(cfgBits)
  );

  function automatic logic [DW-1:0] patA(input int a);
    return DW'(a * 37 + 5);
  endfunction
  function automatic logic [DW-1:0] patB(input int a);
    return DW'(a * 11);
  endfunction
  function automatic logic [DW-1:0] wordAt(input int a);
    return cfgBits[a*DW +: DW];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int a, input logic [DW-1:0] d,
                       input logic [SW-1:0] s);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = AW'(a); cmdData = d; cmdSig = s;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [DEPTH*DW-1:0] snap;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 cmdErr", cmdErr, 0);
    chk("R1 locked", locked, 0);
    chk("R1 rdData", rdData, 0);
    chk("R1 sigOut", sigOut, 0);
    chk("R1 cfgBits", {31'd0, |cfgBits}, 0);

    // R2 program sweep, first pattern
    for (int a = 0; a < DEPTH; a++) begin
      issue(3'd1, a, patA(a), '0);
      chk("R2 done", done, 1);
      chk("R2 err", cmdErr, 0);
      chk("R2 word", wordAt(a), patA(a));
    end
    // R10 pulse ends
    @(negedge clk);
    chk("R10 done low", done, 0);
    chk("R10 err low", cmdErr, 0);
    // R2 second pass ORs
    for (int a = 0; a < DEPTH; a++) issue(3'd1, a, patB(a), '0);
    for (int a = 0; a < DEPTH; a++) chk("R2 or word", wordAt(a), patA(a) | patB(a));
    // R3 verify sweep
    for (int a = 0; a < DEPTH; a++) begin
      issue(3'd2, a, '0, '0);
      chk("R3 done", done, 1);
      chk("R3 rdData", rdData, patA(a) | patB(a));
    end

    // R8 signature write/read unlocked
    issue(3'd4, 0, '0, 24'hA5C317);
    chk("R8 sigwr done", done, 1);
    issue(3'd5, 0, '0, '0);
    chk("R8 sigOut", sigOut, 24'hA5C317);

    // R9 undefined opcodes
    snap = cfgBits;
    for (int op = 6; op < 8; op++) begin
      issue(3'(op), 1, 8'hFF, 24'h111111);
      chk("R9 err", cmdErr, 1);
      chk("R9 done", done, 1);
      chk("R9 cfg same", {31'd0, cfgBits == snap}, 1);
    end
    issue(3'd5, 0, '0, '0);
    chk("R9 sig same", sigOut, 24'hA5C317);

    // R6 lock
    issue(3'd3, 0, '0, '0);
    chk("R6 locked", locked, 1);
    chk("R6 done", done, 1);
    chk("R6 err", cmdErr, 0);

    // R7 refused while locked
    issue(3'd1, 3, 8'hFF, '0);
    chk("R7 prog err", cmdErr, 1);
    chk("R7 prog done", done, 1);
    chk("R7 word same", wordAt(3), patA(3) | patB(3));
    issue(3'd2, 3, '0, '0);
    chk("R7 verify err", cmdErr, 1);
    chk("R7 verify zero", rdData, 0);
    issue(3'd4, 0, '0, 24'h000042);
    chk("R7 sigwr err", cmdErr, 1);
    // R8 sig read while locked
    issue(3'd5, 0, '0, '0);
    chk("R8 locked sigrd err", cmdErr, 0);
    chk("R8 locked sigOut", sigOut, 24'hA5C317);

    // R4 erase with R5 injected command
    issue(3'd0, 0, '0, '0);
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 12) begin
        cmdValid = 1'b1; cmdOp = 3'd1; cmdAddr = '0; cmdData = 8'hFF;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
    chk("R4 busy cycles", n, DEPTH);
    chk("R4 done", done, 1);
    chk("R4 unlocked", locked, 0);
    chk("R4 cfg clear", {31'd0, |cfgBits}, 0);
    chk("R5 word0 untouched", wordAt(0), 0);
    issue(3'd5, 0, '0, '0);
    chk("R4 sig clear", sigOut, 0);

    // after erase, program works again
    issue(3'd1, 2, 8'h3C, '0);
    chk("R2 post erase err", cmdErr, 0);
    issue(3'd2, 2, '0, '0);
    chk("R3 post erase", rdData, 8'h3C);

    finishRun();
  end
endmodule